// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block keeps the exception state of a floating-point arithmetic unit. Each time an operation completes, the unit presents five raw exception indications along with a valid strobe. These are invalid operation, overflow, underflow, divide-by-zero and inexact. The block compares the raised indications against a trap-enable mask held in the same status word. It then does one of two things:

- If no raised exception is enabled, it records the operation as an ordinary update. The current-exception field takes the new flags and the accrued-exception field gathers them.
- If any raised exception is enabled, it reports a trap. It emits a single-cycle trap request and loads the current field with only the exceptions that caused the trap. Any inexact indication that rides along with an overflow or underflow is dropped. The accrued field is not touched.

Software reads the whole status word continuously and may overwrite it through a one-cycle write strobe. A write always wins over an operation that completes in the same cycle. All state changes appear on the outputs one clock after the edge that captures them.

Top module: `fp_exc_status_reg`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the status word reads 0x00000000 and trap_req is low.
- R2: The status word layout is fixed. The current field is bits 4:0, the accrued field is bits 9:5 and the trap-enable mask is bits 27:23. Within each field the order from high to low bit is invalid, overflow, underflow, divide-by-zero, inexact. op_flags uses the same order in bits 4:0. All other status bits always read 0, and data written to them is ignored.
- R3: An accepted operation (op_valid high, sw_wr_en low) with no raised flag enabled has these effects in the next cycle: the current field equals op_flags, the accrued field equals its old value ORed with op_flags, and trap_req stays low. This includes the all-zero op_flags case, which clears the current field.
- R4: An accepted operation whose raised flags include at least one enabled flag drives trap_req high for exactly the following cycle. trap_req is never high without such an operation in the previous cycle.
- R5: On a trapping operation the current field holds the raised-and-enabled flags only. The inexact bit is also cleared when overflow or underflow is among them.
- R6: A trapping operation leaves the accrued field and the trap-enable mask unchanged.
- R7: When sw_wr_en is high, the current, accrued and mask fields load from the matching bits of sw_wr_data. An operation presented in the same cycle is discarded and raises no trap.
- R8: In a cycle with neither op_valid nor sw_wr_en, the status word holds its value and trap_req is low.
- R9: A raised flag whose mask bit is clear never causes a trap, even when other mask bits are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation completed this cycle |
| op_flags | input | 5 | Raw exception flags {invalid, overflow, underflow, div-zero, inexact} |
| sw_wr_en | input | 1 | Software write strobe for the status word |
| sw_wr_data | input | 32 | Status word value to write |
| status_word | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The hardest situations to reach are three. The first is a trap that occurs while the accrued field already holds history, so that a wrongly updated accrued field would be visible. The second is an operation that raises enabled and disabled flags together. The third is a software write landing in the same cycle as a trapping operation. The stimulus reaches them in stages. It first builds accrued history with the mask cleared. It then loads a partial or full mask through a write, and issues operations that mix enabled flags, disabled flags and inexact. Finally it presents an operation and a write on the same edge, then checks that the write image appears and no trap pulse follows.

// File: rtl/fpx_pkg.sv
// Package: shared constants and types for the FP exception status register.
// Assumes the five exception flags are always carried in the same order.
package fpx_pkg;
    localparam int EXC_N  = 5;
    // Bit positions inside a five-bit exception vector.
    localparam int EXC_NX = 0;
    localparam int EXC_DZ = 1;
    localparam int EXC_UF = 2;
    localparam int EXC_OF = 3;
    localparam int EXC_NV = 4;

    typedef logic [EXC_N-1:0] exc_vec_t;
endpackage

// File: rtl/fpx_trap_filter.sv
// Module: fpx_trap_filter
// Purely combinational. It decides whether the raw flags of an operation
// trap, and forms the current-field image that a trap leaves behind.
// Assumes the vector order defined in fpx_pkg.
module fpx_trap_filter
    import fpx_pkg::*;
(
    input  exc_vec_t raw_flags,
    input  exc_vec_t trap_en,
    output logic     trap_hit,
    output exc_vec_t trap_cur
);
    exc_vec_t hit_vec;

    // Flags that are both raised and enabled.
    always_comb begin
        hit_vec  = raw_flags & trap_en;
        trap_hit = |hit_vec;
    end

    // Trap image: enabled hits, with inexact suppressed behind overflow/underflow.
    always_comb begin
        trap_cur = hit_vec;
        if (hit_vec[EXC_OF] || hit_vec[EXC_UF]) begin
            trap_cur[EXC_NX] = 1'b0;
        end
    end
endmodule

// File: rtl/fpx_field_regs.sv
// Module: fpx_field_regs
// Holds the current, accrued and mask fields plus the trap pulse register.
// A software write has priority over an operation. A trapping operation
// freezes the accrued field. Assumes a synchronous active-low reset.
module fpx_field_regs
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  exc_vec_t wr_cur,
    input  exc_vec_t wr_acc,
    input  exc_vec_t wr_mask,
    input  logic     op_valid,
    input  exc_vec_t raw_flags,
    input  logic     trap_hit,
    input  exc_vec_t trap_cur,
    output exc_vec_t cur_q,
    output exc_vec_t acc_q,
    output exc_vec_t mask_q,
    output logic     trap_q
);
    // Field and trap-pulse update with write-over-operation priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            acc_q  <= '0;
            mask_q <= '0;
            trap_q <= 1'b0;
        end else if (wr_en) begin
            cur_q  <= wr_cur;
            acc_q  <= wr_acc;
            mask_q <= wr_mask;
            trap_q <= 1'b0;
        end else if (op_valid && trap_hit) begin
            cur_q  <= trap_cur;
            trap_q <= 1'b1;
        end else if (op_valid) begin
            cur_q  <= raw_flags;
            acc_q  <= acc_q | raw_flags;
            trap_q <= 1'b0;
        end else begin
            trap_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fpx_word_pack.sv
// Module: fpx_word_pack
// Places the three fields into the status word at their parameterised
// positions. Every other bit is tied to zero. Assumes the fields do not overlap.
module fpx_word_pack
    import fpx_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int CUR_LSB  = 0,
    parameter int ACC_LSB  = 5,
    parameter int MASK_LSB = 23
) (
    input  exc_vec_t          cur,
    input  exc_vec_t          acc,
    input  exc_vec_t          mask,
    output logic [WORD_W-1:0] word
);
    localparam int CUR_MSB  = CUR_LSB  + EXC_N - 1;
    localparam int ACC_MSB  = ACC_LSB  + EXC_N - 1;
    localparam int MASK_MSB = MASK_LSB + EXC_N - 1;

    // Per-bit routing of fields into the word.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b >= CUR_LSB && b <= CUR_MSB) begin : g_cur
            assign word[b] = cur[b-CUR_LSB];
        end else if (b >= ACC_LSB && b <= ACC_MSB) begin : g_acc
            assign word[b] = acc[b-ACC_LSB];
        end else if (b >= MASK_LSB && b <= MASK_MSB) begin : g_mask
            assign word[b] = mask[b-MASK_LSB];
        end else begin : g_zero
            assign word[b] = 1'b0;
        end
    end
endmodule

// File: rtl/fp_exc_status_reg.sv
// Module: fp_exc_status_reg (top)
// Floating-point exception status register with a trap-enable mask and a
// one-cycle trap request. Assumes op_flags are valid only while op_valid
// is high, and that software writes are single-cycle strobes.
module fp_exc_status_reg
    import fpx_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int CUR_LSB  = 0,
    parameter int ACC_LSB  = 5,
    parameter int MASK_LSB = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [EXC_N-1:0]  op_flags,
    input  logic              sw_wr_en,
    input  logic [WORD_W-1:0] sw_wr_data,
    output logic [WORD_W-1:0] status_word,
    output logic              trap_req
);
    exc_vec_t wr_cur, wr_acc, wr_mask;
    exc_vec_t cur_q, acc_q, mask_q;
    exc_vec_t trap_cur;
    logic     trap_hit;
    logic     unused_wr_bits;

    // Slice the write image into its fields. The remaining bits have no storage.
    always_comb begin
        wr_cur         = sw_wr_data[CUR_LSB  +: EXC_N];
        wr_acc         = sw_wr_data[ACC_LSB  +: EXC_N];
        wr_mask        = sw_wr_data[MASK_LSB +: EXC_N];
        unused_wr_bits = ^sw_wr_data;
    end

    fpx_trap_filter u_filter (
        .raw_flags (op_flags),
        .trap_en   (mask_q),
        .trap_hit  (trap_hit),
        .trap_cur  (trap_cur)
    );

    fpx_field_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sw_wr_en),
        .wr_cur    (wr_cur),
        .wr_acc    (wr_acc),
        .wr_mask   (wr_mask),
        .op_valid  (op_valid),
        .raw_flags (op_flags),
        .trap_hit  (trap_hit),
        .trap_cur  (trap_cur),
        .cur_q     (cur_q),
        .acc_q     (acc_q),
        .mask_q    (mask_q),
        .trap_q    (trap_req)
    );

    fpx_word_pack #(
        .WORD_W   (WORD_W),
        .CUR_LSB  (CUR_LSB),
        .ACC_LSB  (ACC_LSB),
        .MASK_LSB (MASK_LSB)
    ) u_pack (
        .cur  (cur_q),
        .acc  (acc_q),
        .mask (mask_q),
        .word (status_word)
    );
endmodule

// File: rtl/fpx_status_chk.sv
// Module: fpx_status_chk
// Port-level checker for fp_exc_status_reg, attached with bind.
// Assumes the same field parameters as the design it is bound to.
module fpx_status_chk
    import fpx_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int CUR_LSB  = 0,
    parameter int ACC_LSB  = 5,
    parameter int MASK_LSB = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [EXC_N-1:0]  op_flags,
    input logic              sw_wr_en,
    input logic [WORD_W-1:0] sw_wr_data,
    input logic [WORD_W-1:0] status_word,
    input logic              trap_req
);
    localparam logic [WORD_W-1:0] ONES_N = {{(WORD_W-EXC_N){1'b0}}, {EXC_N{1'b1}}};
    localparam logic [WORD_W-1:0] FIELD_BITS =
        (ONES_N << CUR_LSB) | (ONES_N << ACC_LSB) | (ONES_N << MASK_LSB);

    exc_vec_t cur, acc, mask;
    logic     seen;

    // Field views of the observed status word.
    always_comb begin
        cur  = status_word[CUR_LSB  +: EXC_N];
        acc  = status_word[ACC_LSB  +: EXC_N];
        mask = status_word[MASK_LSB +: EXC_N];
    end

    // Marks that one full cycle out of reset has passed, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R2
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & ~FIELD_BITS) == '0);

    // R3
    plain_update_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(op_valid && !sw_wr_en && ((op_flags & mask) == '0)) |->
        (cur == $past(op_flags)) && (acc == ($past(acc) | $past(op_flags))) && !trap_req);

    // R4
    trap_source_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        trap_req |-> $past(op_valid && !sw_wr_en && ((op_flags & mask) != '0)));

    // R4
    trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(op_valid && !sw_wr_en && ((op_flags & mask) != '0)) |-> trap_req);

    // R5
    trap_image_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        trap_req |-> ((cur & ~$past(op_flags & mask)) == '0) && (cur != '0));

    // R5
    trap_nx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (trap_req && (cur[EXC_OF] || cur[EXC_UF])) |-> !cur[EXC_NX]);

    // R6
    trap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        trap_req |-> $stable(acc) && $stable(mask));

    // R7
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(sw_wr_en) |->
        (status_word == ($past(sw_wr_data) & FIELD_BITS)) && !trap_req);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(!op_valid && !sw_wr_en) |-> $stable(status_word) && !trap_req);
endmodule

bind fp_exc_status_reg fpx_status_chk #(
    .WORD_W   (WORD_W),
    .CUR_LSB  (CUR_LSB),
    .ACC_LSB  (ACC_LSB),
    .MASK_LSB (MASK_LSB)
) u_status_chk (.*);

// File: tb/fp_exc_status_reg_test.sv
// Scoreboard bench: driver tasks push expected results, a monitor pops and compares.
module fp_exc_status_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic [31:0] status_word;
    logic        trap_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_word_q[$];
    logic        exp_trap_q[$];
    string       exp_tag_q[$];

    // Reference state from the requirements.
    logic [4:0] m_cur = '0, m_acc = '0, m_mask = '0;

    always #4 clk = ~clk;

    fp_exc_status_reg uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .status_word(status_word), .trap_req(trap_req)
    );

    function automatic logic [31:0] pack_word();
        return {4'b0, m_mask, 13'b0, m_acc, m_cur};
    endfunction

    task automatic push(input logic trap, input string tag);
        exp_word_q.push_back(pack_word());
        exp_trap_q.push_back(trap);
        exp_tag_q.push_back(tag);
    endtask

    // One bus cycle. Inputs change at the falling edge.
    task automatic cycle(input logic v, input logic [4:0] f,
                         input logic w, input logic [31:0] d, input string tag);
        logic [4:0] hit;
        logic       trap;
        @(negedge clk);
        op_valid = v; op_flags = f; sw_wr_en = w; sw_wr_data = d;
        trap = 1'b0;
        hit  = f & m_mask;
        if (w) begin
            m_cur = d[4:0]; m_acc = d[9:5]; m_mask = d[27:23];
        end else if (v && hit != 0) begin
            trap  = 1'b1;
            m_cur = hit;
            if (hit[3] || hit[2]) m_cur[0] = 1'b0;
        end else if (v) begin
            m_cur = f;
            m_acc = m_acc | f;
        end
        push(trap, tag);
    endtask

    // Monitor: compares shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_word_q.size() != 0) begin
                logic [31:0] ew;
                logic        et;
                string       tg;
                ew = exp_word_q.pop_front();
                et = exp_trap_q.pop_front();
                tg = exp_tag_q.pop_front();
                checks++;
                if (status_word !== ew || trap_req !== et) begin
                    fails++;
                    $display("FAIL %s: word=%h trap=%b expected word=%h trap=%b",
                             tg, status_word, trap_req, ew, et);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cycle(0, 5'b00000, 0, 32'h0, "R1 reset state");
        // R3: ordinary updates with an empty mask
        cycle(1, 5'b00001, 0, 32'h0, "R3 inexact only");
        cycle(1, 5'b01001, 0, 32'h0, "R3 overflow+inexact no trap");
        cycle(1, 5'b00000, 0, 32'h0, "R3 clean op clears current");
        // R8: idle hold
        cycle(0, 5'b11111, 0, 32'h0, "R8 idle hold");
        // R2 / R7: full mask written, spare bits ignored
        cycle(0, 5'b00000, 1, 32'h8F80_1000, "R2 R7 write full mask");
        // R6: rebuild some accrued history through a write, then trap
        cycle(0, 5'b00000, 1, 32'h0F80_0140, "R7 write mask and accrued");
        cycle(1, 5'b01001, 0, 32'h0, "R4 R5 R6 overflow+inexact trap");
        cycle(0, 5'b00000, 0, 32'h0, "R4 trap pulse ends");
        cycle(1, 5'b00101, 0, 32'h0, "R5 underflow+inexact trap");
        cycle(1, 5'b10000, 0, 32'h0, "R4 back-to-back invalid trap");
        cycle(1, 5'b00010, 0, 32'h0, "R5 divide-by-zero trap");
        // R9: partial mask
        cycle(0, 5'b00000, 1, 32'h0800_0000, "R7 invalid-only mask");
        cycle(1, 5'b01001, 0, 32'h0, "R9 disabled flags do not trap");
        cycle(1, 5'b10001, 0, 32'h0, "R5 R6 enabled invalid with disabled inexact");
        // R7: write and trapping op in same cycle
        cycle(1, 5'b10000, 1, 32'h0000_03E0, "R7 write beats trapping op");
        cycle(1, 5'b00001, 0, 32'h0, "R3 accrue after write");
        // inexact alone traps and keeps its bit
        cycle(0, 5'b00000, 1, 32'h0080_0000, "R7 inexact-only mask");
        cycle(1, 5'b00001, 0, 32'h0, "R5 lone inexact trap kept");
        cycle(1, 5'b01000, 0, 32'h0, "R9 overflow disabled under inexact mask");
        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; sw_wr_en = 1'b0;
        m_cur = '0; m_acc = '0; m_mask = '0;
        @(negedge clk);
        rst_n = 1'b1;
        cycle(0, 5'b00000, 0, 32'h0, "R1 reset clears state");
        @(negedge clk);
        op_valid = 1'b0; sw_wr_en = 1'b0;
        while (exp_word_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule